// File: doc/BRIEF.md
# Serial Converter Read Sequencer

This block sits on the host side of an 8-bit sampling converter. The converter has one convert-start line, a serial clock input and a serial data output. On a one-cycle start command the block wakes the converter with a rising edge on convert-start and then begins a conversion with a falling edge on the same line. Next it waits out the conversion time. It then issues eight serial-clock pulses and assembles the returned byte. The received byte is presented with a one-cycle valid strobe.

A mode input, sampled with the start command, decides the level that convert-start is left at after a conversion, and that level sets the converter's sleep behaviour. In auto power-down mode the line stays low through the conversion and afterwards, so the converter sleeps between samples. In high-speed mode the line goes high again a few cycles after the falling edge and before the conversion ends, which keeps the converter awake. Every timing minimum is a parameter counted in system-clock cycles: the wake pulse, the low pulse, the conversion wait, the set-up gap and the serial-clock half period.

Top module: `adc_read_seq`

## Requirements
- R1: During and directly after reset, conv_start_o, ser_clk_o, busy_o and rx_valid_o are 0 and rx_data_o is 0.
- R2: When a start is accepted, conv_start_o is high for exactly WAKE_CYC cycles and then falls. busy_o is 1 from the cycle after the start until the cycle in which rx_valid_o is 1, and 0 in that cycle.
- R3: With sleep_mode_i=1 (auto power-down) the line conv_start_o stays low from its falling edge through the read, and it stays low after the sequence ends.
- R4: With sleep_mode_i=0 (high speed), conv_start_o goes high again exactly LOW_CYC cycles after its falling edge and stays high after the sequence. LOW_CYC is clamped to below CONV_CYC, so the line is high before the conversion ends.
- R5: ser_clk_o stays low until its first rise. In auto power-down mode that rise comes exactly CONV_CYC cycles after the falling edge of conv_start_o. In high-speed mode it comes after the larger of CONV_CYC and LOW_CYC+SETUP_CYC cycles.
- R6: A read consists of exactly 8 ser_clk_o pulses, with high and low phases of exactly HALF_CYC cycles each. ser_clk_o idles low whenever busy_o is 0.
- R7: ser_data_i is captured at each falling edge of ser_clk_o. The first bit captured is placed in rx_data_o[7] and the last in rx_data_o[0].
- R8: rx_valid_o is high for exactly one cycle: the cycle after the eighth falling edge of ser_clk_o. rx_data_o holds its value until the next strobe.
- R9: A start command given while busy_o is 1 is ignored, together with its mode value. The running sequence continues unchanged.
- R10: conv_start_o does not change while the eight clock pulses are being issued.
- R11: A start command given in the cycle in which rx_valid_o is 1 is accepted.
- R12: If conv_start_o is high when an auto power-down start is accepted, the line is first driven low for WAKE_CYC cycles. The wake pulse of R2 follows, so that the converter sees a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to run a convert-and-read sequence |
| sleep_mode_i | input | 1 | 1 = auto power-down, 0 = high speed; sampled with an accepted start |
| ser_data_i | input | 1 | Serial data from the converter |
| conv_start_o | output | 1 | Convert-start / wake line to the converter |
| ser_clk_o | output | 1 | Serial clock to the converter, idles low |
| busy_o | output | 1 | A sequence is running |
| rx_data_o | output | DATA_W | Last received result, MSB received first |
| rx_valid_o | output | 1 | One-cycle strobe for a new rx_data_o |

## Verification
The end of a read and a new start command can fall in the same cycle. The bench provokes this in two ways. First, it places a start on the cycle of the eighth falling serial-clock edge, while the block is still busy; that start must be rejected, and the waveform of every output must still match the computed one. Second, it places a start exactly in the strobe cycle; that start must begin a new wake pulse on the next edge. A behavioural converter in the bench also checks the mode-dependent line level at the end of each conversion, and it reports any read that starts before the result is ready.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PRE  = 3'd1,
        PH_WAKE = 3'd2,
        PH_CONV = 3'd3,
        PH_READ = 3'd4
    } seq_phase_t;

    typedef enum logic {
        MODE_FAST  = 1'b0,
        MODE_SLEEP = 1'b1
    } cnv_mode_t;

    // serial-clock event flags seen by the capture stage
    typedef struct packed {
        logic fall;
        logic last;
    } bit_evt_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // bits needed to count 0 .. n-1
    function automatic int unsigned cwidth(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // low pulse in fast mode must end before the conversion does
    function automatic int unsigned low_clamp(input int unsigned low, input int unsigned conv);
        int unsigned v;
        v = (low < conv) ? low : conv - 1;
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned WAKE_CYC  = 3,
    parameter int unsigned LOW_CYC   = 3,
    parameter int unsigned CONV_CYC  = 625,
    parameter int unsigned SETUP_CYC = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic mode_i,
    input  logic last_i,
    output logic cnv_o,
    output logic busy_o,
    output logic go_o
);
    localparam int unsigned LOW_EFF    = low_clamp(LOW_CYC, CONV_CYC);
    localparam int unsigned WAIT_FAST  = umax(CONV_CYC, LOW_EFF + SETUP_CYC);
    localparam int unsigned WAIT_SLEEP = CONV_CYC;
    localparam int unsigned CNT_TOP    = umax(umax(WAIT_FAST, WAIT_SLEEP), WAKE_CYC);
    localparam int unsigned CW         = cwidth(CNT_TOP);

    localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_CYC - 1);
    localparam logic [CW-1:0] LOW_LAST   = CW'(LOW_EFF - 1);
    localparam logic [CW-1:0] FAST_LAST  = CW'(WAIT_FAST - 1);
    localparam logic [CW-1:0] SLEEP_LAST = CW'(WAIT_SLEEP - 1);

    seq_phase_t     phase_q;
    cnv_mode_t      mode_q;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  wait_last;

    assign wait_last = (mode_q == MODE_SLEEP) ? SLEEP_LAST : FAST_LAST;
    assign busy_o    = (phase_q != PH_IDLE);
    assign go_o      = (phase_q == PH_CONV) && (cnt_q == wait_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            mode_q  <= MODE_FAST;
            cnt_q   <= '0;
            cnv_o   <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        mode_q <= cnv_mode_t'(mode_i);
                        cnt_q  <= '0;
                        if (cnv_o && (cnv_mode_t'(mode_i) == MODE_SLEEP)) begin
                            // line idles high: make room for a fresh rising edge
                            phase_q <= PH_PRE;
                            cnv_o   <= 1'b0;
                        end else begin
                            phase_q <= PH_WAKE;
                            cnv_o   <= 1'b1;
                        end
                    end
                end
                PH_PRE: begin
                    if (cnt_q == WAKE_LAST) begin
                        cnt_q   <= '0;
                        cnv_o   <= 1'b1;
                        phase_q <= PH_WAKE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_WAKE: begin
                    if (cnt_q == WAKE_LAST) begin
                        cnt_q   <= '0;
                        cnv_o   <= 1'b0;
                        phase_q <= PH_CONV;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_CONV: begin
                    if ((mode_q == MODE_FAST) && (cnt_q == LOW_LAST)) begin
                        cnv_o <= 1'b1;
                    end
                    if (cnt_q == wait_last) begin
                        cnt_q   <= '0;
                        phase_q <= PH_READ;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_READ: begin
                    if (last_i) begin
                        phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assert_sleep_low_read_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_READ && mode_q == MODE_SLEEP) |-> !cnv_o);

    assert_fast_high_read_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_READ && mode_q == MODE_FAST) |-> cnv_o);

    assert_line_steady_read_R10: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_READ && $past(phase_q) == PH_READ) |-> $stable(cnv_o));

    assert_busy_keeps_mode_R9: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && start_i) |=> $stable(mode_q));

endmodule

// File: rtl/adc_seq_sclk.sv
module adc_seq_sclk
    import adc_seq_pkg::*;
#(
    parameter int unsigned HALF_CYC = 4,
    parameter int unsigned BITS     = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     go_i,
    output logic     sclk_o,
    output bit_evt_t evt_o
);
    localparam int unsigned HW = cwidth(HALF_CYC);
    localparam int unsigned BW = cwidth(BITS);
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_CYC - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(BITS - 1);

    logic          active_q;
    logic [HW-1:0] half_q;
    logic [BW-1:0] bit_q;

    always_comb begin
        evt_o.fall = sclk_o && (half_q == HALF_LAST);
        evt_o.last = evt_o.fall && (bit_q == BIT_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            sclk_o   <= 1'b0;
            half_q   <= '0;
            bit_q    <= '0;
        end else if (go_i) begin
            active_q <= 1'b1;
            sclk_o   <= 1'b1;
            half_q   <= '0;
            bit_q    <= '0;
        end else if (active_q) begin
            if (half_q == HALF_LAST) begin
                half_q <= '0;
                if (sclk_o) begin
                    sclk_o <= 1'b0;
                    if (bit_q == BIT_LAST) begin
                        active_q <= 1'b0;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end else begin
                    sclk_o <= 1'b1;
                end
            end else begin
                half_q <= half_q + 1'b1;
            end
        end
    end

    assert_no_pulse_after_last_R6: assert property (@(posedge clk) disable iff (rst)
        evt_o.last |=> !sclk_o);

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture
    import adc_seq_pkg::*;
#(
    parameter int unsigned BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  bit_evt_t        evt_i,
    input  logic            sdata_i,
    input  logic            sclk_i,
    output logic [BITS-1:0] data_o,
    output logic            valid_o
);
    logic [BITS-2:0] shift_q;
    logic [BITS-1:0] nxt;

    assign nxt = {shift_q, sdata_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (evt_i.fall) begin
                shift_q <= nxt[BITS-2:0];
            end
            if (evt_i.last) begin
                data_o  <= nxt;
                valid_o <= 1'b1;
            end
        end
    end

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_strobe_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $fell(sclk_i));

endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned WAKE_CYC  = 3,
    parameter int unsigned LOW_CYC   = 3,
    parameter int unsigned CONV_CYC  = 625,
    parameter int unsigned SETUP_CYC = 1,
    parameter int unsigned HALF_CYC  = 4,
    parameter int unsigned DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              sleep_mode_i,
    input  logic              ser_data_i,
    output logic              conv_start_o,
    output logic              ser_clk_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o
);
    logic     go;
    bit_evt_t evt;

    adc_seq_ctrl #(
        .WAKE_CYC (WAKE_CYC),
        .LOW_CYC  (LOW_CYC),
        .CONV_CYC (CONV_CYC),
        .SETUP_CYC(SETUP_CYC)
    ) ctrl_i (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .mode_i (sleep_mode_i),
        .last_i (evt.last),
        .cnv_o  (conv_start_o),
        .busy_o (busy_o),
        .go_o   (go)
    );

    adc_seq_sclk #(
        .HALF_CYC(HALF_CYC),
        .BITS    (DATA_W)
    ) sclk_i (
        .clk   (clk),
        .rst   (rst),
        .go_i  (go),
        .sclk_o(ser_clk_o),
        .evt_o (evt)
    );

    adc_seq_capture #(
        .BITS(DATA_W)
    ) cap_i (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .sdata_i(ser_data_i),
        .sclk_i (ser_clk_o),
        .data_o (rx_data_o),
        .valid_o(rx_valid_o)
    );

    assert_clock_idle_low_R6: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !ser_clk_o);

endmodule

// File: tb/adc_read_seq_tb_top.sv
module adc_read_seq_tb_top;
    localparam int W  = 3;
    localparam int L  = 3;
    localparam int C  = 625;
    localparam int SU = 1;
    localparam int H  = 4;
    localparam int NB = 8;
    localparam int LE  = (L < C) ? L : C - 1;
    localparam int WHS = (C > LE + SU) ? C : LE + SU;
    localparam int WPD = C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic sleep_mode_i = 1'b0;
    logic ser_data_i;
    logic conv_start_o, ser_clk_o, busy_o, rx_valid_o;
    logic [NB-1:0] rx_data_o;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    bit  idle_high = 0;
    logic [7:0] last_val = 8'h00;

    always #4 clk = ~clk;

    adc_read_seq #(
        .WAKE_CYC(W), .LOW_CYC(L), .CONV_CYC(C), .SETUP_CYC(SU), .HALF_CYC(H), .DATA_W(NB)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .sleep_mode_i(sleep_mode_i),
        .ser_data_i(ser_data_i), .conv_start_o(conv_start_o), .ser_clk_o(ser_clk_o),
        .busy_o(busy_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
    );

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // behavioural converter
    logic [7:0] ain = 8'h00, pending, result;
    bit   cur_mode = 0;
    logic prev_cnv, prev_sclk;
    bit   converting;
    int   conv_left, idx;

    always @(posedge clk) begin
        if (rst) begin
            prev_cnv   <= 1'b0;
            prev_sclk  <= 1'b0;
            converting <= 0;
            conv_left  <= 0;
            idx        <= NB;
            ser_data_i <= 1'b0;
            result     <= 8'h00;
            pending    <= 8'h00;
        end else begin
            prev_cnv  <= conv_start_o;
            prev_sclk <= ser_clk_o;
            if (!conv_start_o && prev_cnv) begin
                pending    <= ain;
                conv_left  <= C - 1;
                converting <= 1;
            end else if (converting) begin
                if (conv_left <= 1) begin
                    result     <= pending;
                    converting <= 0;
                    check(conv_start_o == !cur_mode, cur_mode ? "R3" : "R4",
                          "line level at end of conversion", int'(conv_start_o), int'(!cur_mode));
                end else begin
                    conv_left <= conv_left - 1;
                end
            end
            if (conv_start_o && !prev_cnv) begin
                if (idx > 0 && idx < NB) check(0, "R10", "line rose during a read", idx, 0);
                idx <= 0;
            end else if (ser_clk_o && !prev_sclk) begin
                if (converting) check(0, "R5", "read began before conversion end", 1, 0);
                if (idx < NB) begin
                    ser_data_i <= result[NB-1-idx];
                    idx <= idx + 1;
                end
            end
        end
    end

    task automatic run_seq(input bit md, input logic [7:0] val, input bit imm,
                           input int poke_sel, input int gap);
        int p, g, endj, poke_j;
        int b_pre, b_wake, b_rest, b_lead, b_clk, b_valid, b_busy;
        p = (idle_high && md) ? W : 0;
        g = p + W + (md ? WPD : WHS);
        endj = g + 2 * NB * H - H;
        poke_j = (poke_sel == -2) ? endj - 1 : ((poke_sel >= 0) ? 1 + poke_sel % (endj - 1) : -1);
        b_pre = 0; b_wake = 0; b_rest = 0; b_lead = 0; b_clk = 0; b_valid = 0; b_busy = 0;
        check(rx_data_o == last_val, "R8", "result held between strobes", int'(rx_data_o), int'(last_val));
        if (!imm) repeat (gap + 1) @(negedge clk);
        ain = val;
        cur_mode = md;
        start_i = 1'b1;
        sleep_mode_i = md;
        @(negedge clk);
        start_i = 1'b0;
        for (int j = 0; j <= endj; j++) begin
            bit ec, es;
            int d;
            if (j < p) ec = 0;
            else if (j < p + W) ec = 1;
            else if (md) ec = 0;
            else ec = (j >= p + W + LE);
            d = j - g;
            es = (d >= 0 && d < 2 * NB * H) ? (((d / H) % 2) == 0) : 0;
            if (conv_start_o != ec) begin
                if (j < p) b_pre++;
                else if (j < p + W) b_wake++;
                else b_rest++;
            end
            if (ser_clk_o != es) begin
                if (j < g) b_lead++; else b_clk++;
            end
            if (rx_valid_o != (j == endj)) b_valid++;
            if (busy_o != (j < endj)) b_busy++;
            if (j == 0 && imm) check(busy_o == 1'b1, "R11", "start in strobe cycle accepted", int'(busy_o), 1);
            if (j == endj) check(rx_data_o == val, "R7", "received byte", int'(rx_data_o), int'(val));
            if (j == poke_j) begin
                start_i = 1'b1;
                sleep_mode_i = !md;
            end else begin
                start_i = 1'b0;
            end
            if (j < endj) @(negedge clk);
        end
        start_i = 1'b0;
        if (p > 0) check(b_pre == 0, "R12", "low lead-in cycles wrong", b_pre, 0);
        check(b_wake == 0, "R2", "wake pulse cycles wrong", b_wake, 0);
        check(b_rest == 0, md ? "R3" : "R4", "line level cycles wrong after fall", b_rest, 0);
        check(b_lead == 0, "R5", "serial clock before first rise wrong", b_lead, 0);
        check(b_clk == 0, "R6", "serial clock pulse cycles wrong", b_clk, 0);
        check(b_valid == 0, "R8", "strobe cycles wrong", b_valid, 0);
        check(b_busy == 0, "R2", "busy cycles wrong", b_busy, 0);
        if (poke_j >= 0)
            check(b_pre + b_wake + b_rest + b_lead + b_clk + b_valid + b_busy == 0, "R9",
                  "sequence disturbed by start while busy",
                  b_pre + b_wake + b_rest + b_lead + b_clk + b_valid + b_busy, 0);
        last_val = val;
        idle_high = !md;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(conv_start_o == 1'b0, "R1", "reset line", int'(conv_start_o), 0);
        check(ser_clk_o == 1'b0, "R1", "reset clock", int'(ser_clk_o), 0);
        check(busy_o == 1'b0, "R1", "reset busy", int'(busy_o), 0);
        check(rx_valid_o == 1'b0, "R1", "reset strobe", int'(rx_valid_o), 0);
        check(rx_data_o == '0, "R1", "reset data", int'(rx_data_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy_o == 1'b0 && conv_start_o == 1'b0, "R1", "state after reset release",
              int'({busy_o, conv_start_o}), 0);
        void'($urandom(32'h5eed));
        // directed corners
        run_seq(1'b1, 8'h00, 0, -1, 0);
        run_seq(1'b1, 8'hFF, 0, -1, 2);
        run_seq(1'b0, 8'hA5, 0, -1, 0);
        run_seq(1'b0, 8'h5A, 1, -1, 0);   // R11 chained
        run_seq(1'b1, 8'h80, 1, -1, 0);   // R12 after fast mode, chained
        run_seq(1'b0, 8'h01, 0, -2, 0);   // R9 start on last busy cycle
        run_seq(1'b1, 8'h7E, 0, 5, 1);    // R9 early start while busy
        run_seq(1'b1, 8'hC3, 1, -1, 0);
        for (int k = 0; k < 20; k++) begin
            bit md, imm;
            logic [7:0] v;
            int ps, gp;
            md  = $urandom % 2;
            v   = 8'($urandom);
            imm = ($urandom % 4) == 0;
            ps  = (($urandom % 3) == 0) ? int'($urandom % 1000) : -1;
            gp  = $urandom % 4;
            run_seq(md, v, imm, ps, gp);
        end
        repeat (3) @(negedge clk);
        check(rx_valid_o == 1'b0 && busy_o == 1'b0, "R8", "idle after last read",
              int'({rx_valid_o, busy_o}), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule